// File: doc/BRIEF.md
# Split-Index Set-Associative Tag Lookup

This block is the tag side of a level-one data cache that holds 64 sets of 12 ways, with 64-byte lines. A load presents only the untranslated page-offset part of its address. Bits 11:6 of that offset select the set and bits 5:0 give the byte within the line. While the set's tags are being read, the address translation runs alongside. On the next cycle the translated physical page number arrives and is compared against every way of the chosen set at once. The block then reports hit or miss and the hitting way. It also reports the full physical address, which the data array uses to read one word.

Each stored line keeps its tag, a valid flag and a dirty flag. The set number is not stored, because the line's position implies it. A separate fill port installs a tag into a named set. If that tag is already resident, the fill reuses its way. Otherwise the fill takes the lowest empty way. In a full set it replaces the way named by that set's rotating pointer, and it reports whether the replaced line was dirty. If translation is late, the lookup waits in its compare stage and the request port stops taking requests.

Top module: `vipt_lookup`

## Requirements
- R1: After reset no response and no fill acknowledge are produced, req_ready is high, and every line is empty, so the first lookup to any set misses.
- R2: The set is req_voff[11:6] and the line offset is req_voff[5:0]. rsp_paddr equals {xlat_ppn, req_voff}, with the 36-bit page number in bits 47:12.
- R3: A request accepted at clock edge N must have xlat_valid high with its page number during the following cycle. Its response then appears after edge N+1. The hit decision compares only the translated page number against the stored tags, so the same page offset with a different page number misses.
- R4: When a lookup is waiting in the compare stage and xlat_valid is low, no response is issued, req_ready is low and the waiting lookup is kept. The lookup completes in the first cycle in which xlat_valid is high.
- R5: On a hit, rsp_hit is 1 and rsp_way gives the way index (0 to 11) that holds the page number. On a miss, rsp_hit is 0 and rsp_way is 0.
- R6: A fill acknowledge follows every fill by one clock edge. When the tag is not already resident and the set has empty ways, the fill takes the lowest-numbered empty way, with fill_ack_evict 0 and fill_ack_reuse 0.
- R7: A fill into a full set that does not already hold the tag replaces the way named by that set's pointer. Each pointer starts at way 0 after reset. It advances by one after each replacing fill into its set, and it wraps from 11 to 0. The acknowledge shows fill_ack_evict 1, and fill_ack_victim_dirty carries the dirty flag of the replaced line.
- R8: A fill whose tag is already resident in the set writes that same way, with fill_ack_reuse 1 and fill_ack_evict 0. The line's dirty flag is set to fill_dirty, and the set's pointer is left unchanged.
- R9: A lookup in its compare cycle sees the set contents from before a fill accepted at the same edge. The fill becomes visible to compares from the next cycle onward.
- R10: At most one way of a set ever holds a given page number, so a compare never matches more than one way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_voff | input | 12 | Untranslated page offset of the load address |
| req_ready | output | 1 | Request accepted this cycle when high |
| xlat_valid | input | 1 | Translation result present this cycle |
| xlat_ppn | input | 36 | Translated physical page number |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 4 | Hitting way, 0 on miss |
| rsp_paddr | output | 48 | Physical address for the data word read |
| fill_valid | input | 1 | Install a tag this cycle |
| fill_set | input | 6 | Set to install into |
| fill_tag | input | 36 | Page number to install |
| fill_dirty | input | 1 | Dirty flag for the installed line |
| fill_ack_valid | output | 1 | Fill completed |
| fill_ack_way | output | 4 | Way written by the fill |
| fill_ack_evict | output | 1 | A valid line was replaced |
| fill_ack_reuse | output | 1 | The tag was already resident |
| fill_ack_victim_dirty | output | 1 | The replaced line was dirty |

## Verification
A lookup's result is due one edge after its translation is supplied. That is the second edge after acceptance when translation is on time, and later by exactly the number of stalled cycles otherwise. A fill acknowledge is due one edge after the fill. The bench's model advances on every rising edge from the same inputs. It works out the compare result from the contents held before that edge's fill and only then applies the fill. Outputs are compared against the model every cycle, sampled between edges, so stalls, back-to-back lookups and fills that coincide with lookups are all held to those exact cycles.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

  localparam int unsigned DEF_WAYS       = 12;
  localparam int unsigned DEF_SETS       = 64;
  localparam int unsigned DEF_LINE_BYTES = 64;
  localparam int unsigned DEF_PAGE_BITS  = 12;
  localparam int unsigned DEF_PA_W       = 48;

  // outcome of a fill
  typedef enum logic [1:0] {
    FILL_NEW   = 2'd0,
    FILL_REUSE = 2'd1,
    FILL_EVICT = 2'd2
  } fill_kind_e;

endpackage

// File: rtl/vipt_way_match.sv
module vipt_way_match #(
  parameter int unsigned WAYS  = 12,
  parameter int unsigned TAG_W = 36,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [TAG_W-1:0] tags_i [WAYS],
  input  logic [TAG_W-1:0] key_i,
  output logic [WAYS-1:0]  match_o,
  output logic             any_o,
  output logic [WAY_W-1:0] idx_o
);

  // one comparator per way, all in parallel
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_o[w] = valid_i[w] && (tags_i[w] == key_i);
  end

  assign any_o = |match_o;

  always_comb begin
    idx_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_o[w]) idx_o = WAY_W'(w);
    end
  end

endmodule

// File: rtl/vipt_victim_sel.sv
module vipt_victim_sel
  import vipt_pkg::*;
#(
  parameter int unsigned WAYS = 12,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic             hit_i,
  input  logic [WAY_W-1:0] hit_way_i,
  input  logic [WAY_W-1:0] rr_i,
  output logic [WAY_W-1:0] way_o,
  output fill_kind_e       kind_o
);

  logic [WAY_W-1:0] free_way;
  logic             has_free;

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) free_way = WAY_W'(w);
    end
    has_free = ~&valid_i;
  end

  always_comb begin
    if (hit_i) begin
      way_o  = hit_way_i;
      kind_o = FILL_REUSE;
    end else if (has_free) begin
      way_o  = free_way;
      kind_o = FILL_NEW;
    end else begin
      way_o  = rr_i;
      kind_o = FILL_EVICT;
    end
  end

endmodule

// File: rtl/vipt_tag_store.sv
module vipt_tag_store
  import vipt_pkg::*;
#(
  parameter int unsigned WAYS  = 12,
  parameter int unsigned SETS  = 64,
  parameter int unsigned TAG_W = 36,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_ni,
  // compare read port
  input  logic [SET_W-1:0] rd_set_i,
  output logic [WAYS-1:0]  rd_valid_o,
  output logic [TAG_W-1:0] rd_tag_o [WAYS],
  // fill port
  input  logic             fill_valid_i,
  input  logic [SET_W-1:0] fill_set_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             fill_dirty_i,
  output logic             ack_valid_o,
  output logic [WAY_W-1:0] ack_way_o,
  output fill_kind_e       ack_kind_o,
  output logic             ack_vdirty_o
);

  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [WAY_W-1:0] rr_q    [SETS];

  logic [TAG_W-1:0] fl_tags [WAYS];
  logic [WAYS-1:0]  fl_valid;
  logic [WAYS-1:0]  fl_match;
  logic             fl_hit;
  logic [WAY_W-1:0] fl_hit_way;
  logic [WAY_W-1:0] fl_rr;
  logic [WAY_W-1:0] fl_way;
  fill_kind_e       fl_kind;
  logic [WAY_W-1:0] rr_step;
  logic             fl_vdirty;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      rd_tag_o[w] = tag_q[rd_set_i][w];
      fl_tags[w]  = tag_q[fill_set_i][w];
    end
  end
  assign rd_valid_o = valid_q[rd_set_i];
  assign fl_valid   = valid_q[fill_set_i];
  assign fl_rr      = rr_q[fill_set_i];

  vipt_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) fill_match_i (
    .valid_i (fl_valid),
    .tags_i  (fl_tags),
    .key_i   (fill_tag_i),
    .match_o (fl_match),
    .any_o   (fl_hit),
    .idx_o   (fl_hit_way)
  );

  vipt_victim_sel #(.WAYS(WAYS)) victim_i (
    .valid_i   (fl_valid),
    .hit_i     (fl_hit),
    .hit_way_i (fl_hit_way),
    .rr_i      (fl_rr),
    .way_o     (fl_way),
    .kind_o    (fl_kind)
  );

  // next-state terms for the fill
  always_comb begin
    rr_step   = (fl_rr == WAY_W'(WAYS - 1)) ? '0 : fl_rr + 1'b1;
    fl_vdirty = (fl_kind == FILL_EVICT) && dirty_q[fill_set_i][fl_way];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else if (fill_valid_i) begin
      valid_q[fill_set_i][fl_way] <= 1'b1;
      dirty_q[fill_set_i][fl_way] <= fill_dirty_i;
      if (fl_kind == FILL_EVICT) rr_q[fill_set_i] <= rr_step;
    end
  end

  // tag storage carries no reset; valid flags qualify it
  always_ff @(posedge clk) begin
    if (fill_valid_i) tag_q[fill_set_i][fl_way] <= fill_tag_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ack_valid_o <= 1'b0;
    else         ack_valid_o <= fill_valid_i;
  end

  always_ff @(posedge clk) begin
    if (fill_valid_i) begin
      ack_way_o    <= fl_way;
      ack_kind_o   <= fl_kind;
      ack_vdirty_o <= fl_vdirty;
    end
  end

  // R6: every fill is acknowledged on the next edge
  p_fill_acked_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    fill_valid_i |=> ack_valid_o);

  // R7: no replacement while the set still has room or holds the tag
  p_no_evict_with_room_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (fill_valid_i && (!(&fl_valid) || fl_hit)) |=> (ack_kind_o != FILL_EVICT));

  // R7: a replacement uses the way the pointer named before the fill
  p_evict_at_ptr_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (fill_valid_i && (&fl_valid) && !fl_hit) |=> (ack_way_o == $past(fl_rr)));

  // R10: a resident tag is never written into a second way
  p_fill_single_match_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    fill_valid_i |-> $onehot0(fl_match));

endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
  import vipt_pkg::*;
#(
  parameter int unsigned WAYS       = DEF_WAYS,
  parameter int unsigned SETS       = DEF_SETS,
  parameter int unsigned LINE_BYTES = DEF_LINE_BYTES,
  parameter int unsigned PAGE_BITS  = DEF_PAGE_BITS,
  parameter int unsigned PA_W       = DEF_PA_W,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned OFF_W = $clog2(LINE_BYTES),
  localparam int unsigned TAG_W = PA_W - PAGE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [PAGE_BITS-1:0] req_voff,
  output logic             req_ready,
  input  logic             xlat_valid,
  input  logic [TAG_W-1:0] xlat_ppn,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [WAY_W-1:0] rsp_way,
  output logic [PA_W-1:0]  rsp_paddr,
  input  logic             fill_valid,
  input  logic [SET_W-1:0] fill_set,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_dirty,
  output logic             fill_ack_valid,
  output logic [WAY_W-1:0] fill_ack_way,
  output logic             fill_ack_evict,
  output logic             fill_ack_reuse,
  output logic             fill_ack_victim_dirty
);

  // set index and line offset must sit inside the untranslated bits
  if (SET_W + OFF_W != PAGE_BITS) begin : g_bad_split
    $error("set index plus offset must equal the page offset width");
  end

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  // compare stage
  logic                 s1_valid_q, s1_valid_d;
  logic [PAGE_BITS-1:0] s1_voff_q;
  logic                 accept;
  logic [SET_W-1:0]     s1_set;

  assign req_ready = !s1_valid_q || xlat_valid;
  assign accept    = req_valid && req_ready;
  assign s1_set    = s1_voff_q[OFF_W +: SET_W];

  always_comb begin
    if (accept)          s1_valid_d = 1'b1;
    else if (xlat_valid) s1_valid_d = 1'b0;
    else                 s1_valid_d = s1_valid_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) s1_valid_q <= 1'b0;
    else        s1_valid_q <= s1_valid_d;
  end

  always_ff @(posedge clk) begin
    if (accept) s1_voff_q <= req_voff;
  end

  // tag read and parallel compare
  logic [WAYS-1:0]  rd_valid;
  logic [TAG_W-1:0] rd_tag [WAYS];
  logic [WAYS-1:0]  lk_match;
  logic             lk_hit;
  logic [WAY_W-1:0] lk_way;
  fill_kind_e       ack_kind;

  vipt_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) store_i (
    .clk          (clk),
    .rst_ni       (rst_i),
    .rd_set_i     (s1_set),
    .rd_valid_o   (rd_valid),
    .rd_tag_o     (rd_tag),
    .fill_valid_i (fill_valid),
    .fill_set_i   (fill_set),
    .fill_tag_i   (fill_tag),
    .fill_dirty_i (fill_dirty),
    .ack_valid_o  (fill_ack_valid),
    .ack_way_o    (fill_ack_way),
    .ack_kind_o   (ack_kind),
    .ack_vdirty_o (fill_ack_victim_dirty)
  );

  vipt_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) look_match_i (
    .valid_i (rd_valid),
    .tags_i  (rd_tag),
    .key_i   (xlat_ppn),
    .match_o (lk_match),
    .any_o   (lk_hit),
    .idx_o   (lk_way)
  );

  assign fill_ack_evict = (ack_kind == FILL_EVICT);
  assign fill_ack_reuse = (ack_kind == FILL_REUSE);

  // response stage
  logic             rsp_valid_d;
  logic             rsp_hit_d;
  logic [WAY_W-1:0] rsp_way_d;
  logic [PA_W-1:0]  rsp_paddr_d;

  always_comb begin
    rsp_valid_d = s1_valid_q && xlat_valid;
    rsp_hit_d   = lk_hit;
    rsp_way_d   = lk_hit ? lk_way : '0;
    rsp_paddr_d = {xlat_ppn, s1_voff_q};
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) rsp_valid <= 1'b0;
    else        rsp_valid <= rsp_valid_d;
  end

  always_ff @(posedge clk) begin
    if (rsp_valid_d) begin
      rsp_hit   <= rsp_hit_d;
      rsp_way   <= rsp_way_d;
      rsp_paddr <= rsp_paddr_d;
    end
  end

  // R4: a waiting lookup is held and nothing is reported
  p_stall_holds_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (s1_valid_q && !xlat_valid) |=> (s1_valid_q && !rsp_valid && $stable(s1_voff_q)));

  // R4: the request port only closes behind a waiting lookup
  p_ready_low_only_stalled_r4: assert property (@(posedge clk) disable iff (!rst_i)
    !req_ready |-> s1_valid_q);

  // R3: a result needs a lookup and a translation on the previous cycle
  p_rsp_after_xlat_r3: assert property (@(posedge clk) disable iff (!rst_i)
    rsp_valid |-> ($past(s1_valid_q) && $past(xlat_valid)));

  // R10: a compare matches at most one way
  p_lookup_single_match_r10: assert property (@(posedge clk) disable iff (!rst_i)
    s1_valid_q |-> $onehot0(lk_match));

endmodule

// File: tb/vipt_lookup_tb.sv
module vipt_lookup_tb_top;

  localparam int NW = 12;
  localparam int NS = 64;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [11:0] req_voff;
  logic        req_ready;
  logic        xlat_valid;
  logic [35:0] xlat_ppn;
  logic        rsp_valid, rsp_hit;
  logic [3:0]  rsp_way;
  logic [47:0] rsp_paddr;
  logic        fill_valid;
  logic [5:0]  fill_set;
  logic [35:0] fill_tag;
  logic        fill_dirty;
  logic        fill_ack_valid;
  logic [3:0]  fill_ack_way;
  logic        fill_ack_evict, fill_ack_reuse, fill_ack_victim_dirty;

  vipt_lookup dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_voff(req_voff), .req_ready(req_ready),
    .xlat_valid(xlat_valid), .xlat_ppn(xlat_ppn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_paddr(rsp_paddr),
    .fill_valid(fill_valid), .fill_set(fill_set), .fill_tag(fill_tag), .fill_dirty(fill_dirty),
    .fill_ack_valid(fill_ack_valid), .fill_ack_way(fill_ack_way),
    .fill_ack_evict(fill_ack_evict), .fill_ack_reuse(fill_ack_reuse),
    .fill_ack_victim_dirty(fill_ack_victim_dirty)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int tests_run = 0;
  int tests_failed = 0;
  bit finished = 0;

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit          m_v [NS][NW];
  bit          m_d [NS][NW];
  logic [35:0] m_t [NS][NW];
  int          m_rr [NS];
  bit          m_s1v;
  logic [11:0] m_s1off;
  bit          e_rsp_v, e_rsp_hit;
  int          e_rsp_way;
  logic [47:0] e_rsp_pa;
  bit          e_ack_v, e_ack_ev, e_ack_re, e_ack_vd;
  int          e_ack_way;
  bit          in_reset;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) begin
        m_rr[s] = 0;
        for (int w = 0; w < NW; w++) begin m_v[s][w] = 0; m_d[s][w] = 0; end
      end
      m_s1v = 0; e_rsp_v = 0; e_ack_v = 0;
    end else begin
      bit rdy;
      int s;
      int hw;
      rdy = !m_s1v || xlat_valid;
      // compare against contents before this edge's fill (R9)
      e_rsp_v = 0;
      if (m_s1v && xlat_valid) begin
        s = int'(m_s1off[11:6]);
        hw = -1;
        for (int w = 0; w < NW; w++) if (m_v[s][w] && m_t[s][w] == xlat_ppn) hw = w;
        e_rsp_v = 1;
        e_rsp_hit = (hw >= 0);
        e_rsp_way = (hw >= 0) ? hw : 0;
        e_rsp_pa = {xlat_ppn, m_s1off};
        m_s1v = 0;
      end
      if (req_valid && rdy) begin
        m_s1v = 1;
        m_s1off = req_voff;
      end
      e_ack_v = 0;
      if (fill_valid) begin
        int fs;
        int way;
        fs = int'(fill_set);
        way = -1;
        e_ack_ev = 0; e_ack_re = 0; e_ack_vd = 0;
        for (int w = 0; w < NW; w++) if (m_v[fs][w] && m_t[fs][w] == fill_tag) way = w;
        if (way >= 0) e_ack_re = 1;
        else begin
          for (int w = NW - 1; w >= 0; w--) if (!m_v[fs][w]) way = w;
          if (way < 0) begin
            way = m_rr[fs];
            e_ack_ev = 1;
            e_ack_vd = m_d[fs][way];
            m_rr[fs] = (m_rr[fs] + 1) % NW;
          end
        end
        m_v[fs][way] = 1; m_d[fs][way] = fill_dirty; m_t[fs][way] = fill_tag;
        e_ack_v = 1;
        e_ack_way = way;
      end
    end
  end

  // compare every cycle, between edges
  always @(negedge clk) begin
    #2;
    if (!finished) begin
      if (in_reset) begin
        check("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        check("R1", "fill_ack_valid in reset", 64'(fill_ack_valid), 64'd0);
        check("R1", "req_ready in reset", 64'(req_ready), 64'd1);
      end else begin
        check("R4", "req_ready", 64'(req_ready), 64'(!m_s1v || xlat_valid));
        check("R3", "rsp_valid", 64'(rsp_valid), 64'(e_rsp_v));
        if (e_rsp_v && rsp_valid) begin
          check("R5", "rsp_hit", 64'(rsp_hit), 64'(e_rsp_hit));
          check("R5", "rsp_way", 64'(rsp_way), 64'(e_rsp_way));
          check("R2", "rsp_paddr", 64'(rsp_paddr), 64'(e_rsp_pa));
        end
        check("R6", "fill_ack_valid", 64'(fill_ack_valid), 64'(e_ack_v));
        if (e_ack_v && fill_ack_valid) begin
          string r;
          r = e_ack_re ? "R8" : (e_ack_ev ? "R7" : "R6");
          check(r, "fill_ack_way", 64'(fill_ack_way), 64'(e_ack_way));
          check(r, "fill_ack_evict", 64'(fill_ack_evict), 64'(e_ack_ev));
          check(r, "fill_ack_reuse", 64'(fill_ack_reuse), 64'(e_ack_re));
          check(r, "fill_ack_victim_dirty", 64'(fill_ack_victim_dirty), 64'(e_ack_vd));
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lookup(input logic [5:0] set, input logic [5:0] off,
                        input logic [35:0] ppn, input int stall);
    @(negedge clk);
    req_valid = 1; req_voff = {set, off};
    @(negedge clk);
    req_valid = 0; xlat_valid = 0;
    repeat (stall) @(negedge clk);
    xlat_valid = 1; xlat_ppn = ppn;
    @(negedge clk);
    xlat_valid = 0;
  endtask

  task automatic fill(input logic [5:0] set, input logic [35:0] tag, input bit dirty);
    @(negedge clk);
    fill_valid = 1; fill_set = set; fill_tag = tag; fill_dirty = dirty;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      tests_failed++;
      tests_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    req_valid = 0; req_voff = '0; xlat_valid = 0; xlat_ppn = '0;
    fill_valid = 0; fill_set = '0; fill_tag = '0; fill_dirty = 0;
    in_reset = 1;
    rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(1);
    in_reset = 0;
    idle(4);

    // R1: empty after reset, first lookups miss
    lookup(6'd5, 6'd3, 36'h0_1234_5678, 0);
    lookup(6'd63, 6'd63, 36'hF_FFFF_FFFF, 0);

    // R6: fills take the lowest empty ways
    fill(6'd5, 36'hA_AAAA_0001, 0);
    fill(6'd5, 36'hB_BBBB_0002, 1);
    // R3/R5: translated page number decides the hit, same offset
    lookup(6'd5, 6'd3, 36'hA_AAAA_0001, 0);
    lookup(6'd5, 6'd40, 36'hB_BBBB_0002, 0);
    lookup(6'd5, 6'd3, 36'hC_CCCC_0003, 0);
    // same tag in a different set misses (R2 index bits)
    lookup(6'd6, 6'd3, 36'hA_AAAA_0001, 0);

    // R4: late translation with a second request waiting
    @(negedge clk);
    req_valid = 1; req_voff = {6'd5, 6'd1};
    @(negedge clk);
    req_voff = {6'd5, 6'd2};
    xlat_valid = 0;
    idle(3);
    xlat_valid = 1; xlat_ppn = 36'hB_BBBB_0002;
    @(negedge clk);
    req_valid = 0;
    xlat_valid = 1; xlat_ppn = 36'hA_AAAA_0001;
    @(negedge clk);
    xlat_valid = 0;
    idle(2);

    // R3: back-to-back lookups, translation one cycle behind each
    @(negedge clk);
    req_valid = 1; req_voff = {6'd5, 6'd0};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      req_voff = {6'd5, 6'(i + 1)};
      xlat_valid = 1;
      xlat_ppn = (i % 2 == 0) ? 36'hA_AAAA_0001 : 36'h1_0000_0000 + 36'(i);
    end
    @(negedge clk);
    req_valid = 0; xlat_valid = 1; xlat_ppn = 36'hB_BBBB_0002;
    @(negedge clk);
    xlat_valid = 0;
    idle(2);

    // R6/R7: fill set 9 (4 KB stride aliases) until full, then replace with wrap
    for (int i = 0; i < NW; i++) fill(6'd9, 36'h2_0000_0000 + 36'(i), (i % 3) == 0);
    // R8: refill resident tag of way 4 as dirty, pointer unchanged
    fill(6'd9, 36'h2_0000_0004, 1);
    for (int i = 0; i < NW + 3; i++) fill(6'd9, 36'h3_0000_0000 + 36'(i), (i % 2) == 1);
    // R8: reuse after replacement
    fill(6'd9, 36'h3_0000_0001, 0);
    fill(6'd9, 36'h3_0000_0001, 1);
    for (int i = 0; i < 4; i++) lookup(6'd9, 6'(i * 7), 36'h3_0000_0000 + 36'(i * 5), i % 2);
    lookup(6'd9, 6'd0, 36'h2_0000_0004, 0);

    // R9: fill at the same edge as a compare is not seen by that compare
    @(negedge clk);
    req_valid = 1; req_voff = {6'd20, 6'd8};
    @(negedge clk);
    req_valid = 1; req_voff = {6'd20, 6'd9};
    xlat_valid = 1; xlat_ppn = 36'h7_7777_7777;
    fill_valid = 1; fill_set = 6'd20; fill_tag = 36'h7_7777_7777; fill_dirty = 0;
    @(negedge clk);
    req_valid = 0; fill_valid = 0;
    xlat_valid = 1; xlat_ppn = 36'h7_7777_7777;
    @(negedge clk);
    xlat_valid = 0;
    idle(3);

    // R10: repeated fills of one tag never create a second match
    fill(6'd20, 36'h7_7777_7777, 1);
    lookup(6'd20, 6'd0, 36'h7_7777_7777, 2);

    idle(4);
    finish_run();
  end

endmodule